// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the software-facing side of a memory-to-memory DMA controller. A processor reaches it through a simple register bus with word-aligned byte offsets. It holds the per-channel programming and the controller-wide configuration. It also collects completion and error events from a data-movement engine, which lies outside this block, and turns them into one interrupt line.

The `NUM_CH` parameter builds the unit with either eight or two channels. The channel count sets which per-channel slots exist and the first byte of the identification area. A two-channel build treats slots 2 to 7 as illegal. Any access to an illegal slot is refused and reported on a one-cycle error flag.

The engine has two pulse inputs per channel, `eng_done` and `eng_err`. A completion pulse sets that channel's terminal-count status bit and clears the channel's enable bit. An error pulse sets the channel's error status bit. Software clears status bits by writing ones to the clear registers.

Top module: `dma_regif`

## Requirements
- R1: `NUM_CH` is 8 or 2. The channel window is byte offsets 0x100 to 0x1FF, and the channel index is offset bits [7:5], giving 32 bytes per channel. Within a slot, +0x0 is the source address, +0x4 the destination address and +0x8 the control word, each full 32-bit read/write.
- R2: The slot word at +0xC is the channel configuration: bit 0 channel enable, bit 1 error interrupt enable, bit 2 terminal-count interrupt enable. Its bits [31:3] read 0, and slot words +0x10 to +0x1C read 0.
- R3: An access to a slot whose index is at or above `NUM_CH` is illegal. `bad_offset` is high in the cycle after such an access and low after any other access. An illegal read returns 0, and an illegal write changes no state.
- R4: Offsets 0xFE0 + 4k (k = 0..7) return one identification byte each in bits [7:0]: 0x80 (8-channel) or 0x81 (2-channel), then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R5: Offset 0x14 is the global configuration: bit 0 controller enable, bit 1 master-1 byte order, bit 2 master-2 byte order. It is read/write, and bits [31:3] read 0.
- R6: Offset 0x10 reads one bit per implemented channel, equal to that channel's enable bit. Other bits read 0.
- R7: Offset 0x18 is the terminal-count mask, where bit c equals channel c's terminal-count interrupt enable. Offset 0x1C is the error mask, built the same way from the error interrupt enables. Both are read-only.
- R8: An `eng_done[c]` pulse sets bit c of the terminal-count status at offset 0x00 and clears channel c's enable bit. This also applies when a configuration write sets the enable in the same cycle.
- R9: An `eng_err[c]` pulse sets bit c of the error status at offset 0x08.
- R10: Writing a 1 to bit c of offset 0x04 (terminal-count clear) or 0x0C (error clear) clears that status bit. Writing 0 has no effect. A set pulse in the same cycle wins over the clear.
- R11: `irq` is high exactly when (terminal-count status AND terminal-count mask) or (error status AND error mask) is nonzero. It follows the state registers with no added delay.
- R12: Synchronous active-high reset clears all channel registers, status, global configuration and `bad_offset`, and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational during a read |
| eng_done | input | NUM_CH | Per-channel completion pulse from the engine |
| eng_err | input | NUM_CH | Per-channel error pulse from the engine |
| irq | output | 1 | Combined interrupt |
| bad_offset | output | 1 | Illegal channel access, one cycle after it |

## Verification
The bench uses a two-channel build. It writes to slot 2, which would alias channel 0 if the decoder kept only the low index bit; a design with that bug would overwrite channel 0's source address without flagging the access. The bench also drives a completion pulse in the same cycle as a status clear, and in the same cycle as a configuration write that sets the enable. A wrong priority there would lose a completion or leave a finished channel enabled. Interrupt checks cover a channel that has status set but its mask clear, so a design that ignored the masks would raise `irq` wrongly. The identification reads catch a first byte that does not follow the channel count.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    typedef struct packed {
        logic tc_ie;
        logic err_ie;
        logic en;
    } chan_cfg_t;

    typedef struct packed {
        logic m2_be;
        logic m1_be;
        logic ctl_en;
    } glob_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    // Global word indices (offset bits [4:2] inside 0x000..0x01F)
    localparam logic [2:0] G_TC_STAT  = 3'd0;
    localparam logic [2:0] G_TC_CLR   = 3'd1;
    localparam logic [2:0] G_ERR_STAT = 3'd2;
    localparam logic [2:0] G_ERR_CLR  = 3'd3;
    localparam logic [2:0] G_ENABLED  = 3'd4;
    localparam logic [2:0] G_CONFIG   = 3'd5;
    localparam logic [2:0] G_TC_MASK  = 3'd6;
    localparam logic [2:0] G_ERR_MASK = 3'd7;

    // Slot word indices
    localparam logic [2:0] S_SRC  = 3'd0;
    localparam logic [2:0] S_DST  = 3'd1;
    localparam logic [2:0] S_CTRL = 3'd2;
    localparam logic [2:0] S_CFG  = 3'd3;

    function automatic logic [7:0] id_byte(int nch, logic [2:0] k);
        case (k)
            3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    word_sel,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    output logic [DW-1:0] rdata,
    output chan_cfg_t     cfg
);

    logic [DW-1:0] src_q, dst_q, ctrl_q;
    chan_cfg_t     cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (wr_en) begin
                case (word_sel)
                    S_SRC:   src_q  <= wdata;
                    S_DST:   dst_q  <= wdata;
                    S_CTRL:  ctrl_q <= wdata;
                    S_CFG:   cfg_q  <= chan_cfg_t'(wdata[CFG_W-1:0]);
                    default: ;
                endcase
            end
            if (done) cfg_q.en <= 1'b0;
        end
    end

    always_comb begin
        case (word_sel)
            S_SRC:   rdata = src_q;
            S_DST:   rdata = dst_q;
            S_CTRL:  rdata = ctrl_q;
            S_CFG:   rdata = DW'(cfg_q);
            default: rdata = '0;
        endcase
    end

    assign cfg = cfg_q;

    assert_done_disables_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !cfg_q.en);

endmodule

// File: rtl/dmareg_status.sv
module dmareg_status #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    input  logic [NCH-1:0] tc_clr,
    input  logic [NCH-1:0] err_clr,
    input  logic [NCH-1:0] tc_mask,
    input  logic [NCH-1:0] err_mask,
    output logic [NCH-1:0] tc_stat,
    output logic [NCH-1:0] err_stat,
    output logic           irq
);

    logic [NCH-1:0] tc_q, err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q  <= '0;
            err_q <= '0;
        end else begin
            tc_q  <= (tc_q  & ~tc_clr)  | tc_set;
            err_q <= (err_q & ~err_clr) | err_set;
        end
    end

    assign tc_stat  = tc_q;
    assign err_stat = err_q;
    assign irq      = (|(tc_q & tc_mask)) | (|(err_q & err_mask));

    assert_set_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (|tc_set) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

    assert_clear_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (|(err_clr & ~err_set)) |=> ((err_q & $past(err_clr & ~err_set)) == '0));

    assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
        (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

    assert_reset_clears_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tc_q == '0 && err_q == '0));

endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dmareg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int AW     = 12,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] eng_done,
    input  logic [NUM_CH-1:0] eng_err,
    output logic              irq,
    output logic              bad_offset
);

    localparam int         IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [3:0] CH_LIM = 4'(NUM_CH);

    initial assert (NUM_CH == 8 || NUM_CH == 2);

    // Address decode
    logic       win_chan, win_id, win_glob, illegal;
    logic [2:0] ch_idx, word_sel;

    assign win_chan = (bus_addr[AW-1:8] == (AW-8)'(1));
    assign win_id   = (bus_addr[AW-1:5] == {(AW-5){1'b1}});
    assign win_glob = (bus_addr[AW-1:5] == '0);
    assign ch_idx   = bus_addr[7:5];
    assign word_sel = bus_addr[4:2];
    assign illegal  = win_chan && ({1'b0, ch_idx} >= CH_LIM);

    logic wr_ok, glob_wr;
    assign wr_ok   = bus_sel && bus_wr && !illegal;
    assign glob_wr = bus_sel && bus_wr && win_glob;

    // Channels
    logic [DW-1:0]     ch_rd [NUM_CH];
    chan_cfg_t         ch_cfg [NUM_CH];
    logic [NUM_CH-1:0] en_vec, tc_mask, err_mask;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dmareg_chan #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_ok && win_chan && (ch_idx == 3'(c))),
            .word_sel (word_sel),
            .wdata    (bus_wdata),
            .done     (eng_done[c]),
            .rdata    (ch_rd[c]),
            .cfg      (ch_cfg[c])
        );
        assign en_vec[c]   = ch_cfg[c].en;
        assign tc_mask[c]  = ch_cfg[c].tc_ie;
        assign err_mask[c] = ch_cfg[c].err_ie;
    end

    // Status and interrupt
    logic [NUM_CH-1:0] tc_stat, err_stat, tc_clr, err_clr;

    assign tc_clr  = (glob_wr && word_sel == G_TC_CLR)  ? bus_wdata[NUM_CH-1:0] : '0;
    assign err_clr = (glob_wr && word_sel == G_ERR_CLR) ? bus_wdata[NUM_CH-1:0] : '0;

    dmareg_status #(.NCH(NUM_CH)) u_status (
        .clk      (clk),
        .rst      (rst),
        .tc_set   (eng_done),
        .err_set  (eng_err),
        .tc_clr   (tc_clr),
        .err_clr  (err_clr),
        .tc_mask  (tc_mask),
        .err_mask (err_mask),
        .tc_stat  (tc_stat),
        .err_stat (err_stat),
        .irq      (irq)
    );

    // Global configuration and bad-offset flag
    glob_cfg_t gcfg_q;
    logic      bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            if (glob_wr && word_sel == G_CONFIG)
                gcfg_q <= glob_cfg_t'(bus_wdata[$bits(glob_cfg_t)-1:0]);
            bad_q <= bus_sel && illegal;
        end
    end

    assign bad_offset = bad_q;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (win_chan && !illegal) begin
            bus_rdata = ch_rd[ch_idx[IW-1:0]];
        end else if (win_id) begin
            bus_rdata = DW'(id_byte(NUM_CH, word_sel));
        end else if (win_glob) begin
            case (word_sel)
                G_TC_STAT:  bus_rdata = DW'(tc_stat);
                G_ERR_STAT: bus_rdata = DW'(err_stat);
                G_ENABLED:  bus_rdata = DW'(en_vec);
                G_CONFIG:   bus_rdata = DW'(gcfg_q);
                G_TC_MASK:  bus_rdata = DW'(tc_mask);
                G_ERR_MASK: bus_rdata = DW'(err_mask);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assert_illegal_write_inert_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && illegal && eng_done == '0) |=> $stable(en_vec));

    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((tc_stat | err_stat) != '0));

    assert_illegal_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && illegal) |-> (bus_rdata == '0));

endmodule

// File: tb/dma_regif_bench.sv
module dma_regif_bench;

    localparam int NCH = 2;
    localparam int DW  = 32;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 bad_offset
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NCH-1:0]    eng_done = '0;
    logic [NCH-1:0]    eng_err = '0;
    logic              irq;
    logic              bad_offset;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    ended = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    dma_regif #(.NUM_CH(NCH)) u_dma_regif (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .irq(irq), .bad_offset(bad_offset)
    );

    // Monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = {31'd0, irq};
                default: act = {31'd0, bad_offset};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [11:0] slot(int c, int w);
        return 12'(32'h100 + 32 * c + 4 * w);
    endfunction

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d,
                      logic [NCH-1:0] dn = '0, logic [NCH-1:0] er = '0);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        eng_done = dn; eng_err = er;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0; eng_done = '0; eng_err = '0;
    endtask

    task automatic pulse(logic [NCH-1:0] dn, logic [NCH-1:0] er);
        @(posedge clk); #1;
        eng_done = dn; eng_err = er;
        @(posedge clk); #1;
        eng_done = '0; eng_err = '0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        push(0, exp, tag);
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic chk_irq(logic v, string tag);
        push(1, {31'd0, v}, tag);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!ended) begin
            ended = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R12 reset state
        rd(12'h000, 0, "R12 tc status");
        rd(12'h008, 0, "R12 err status");
        rd(12'h010, 0, "R12 enabled");
        rd(12'h014, 0, "R12 global cfg");
        rd(slot(0, 0), 0, "R12 ch0 src");
        chk_irq(0, "R12 irq");

        // R1 channel registers
        wr(slot(0, 0), 32'hA5A5_0001);
        wr(slot(1, 1), 32'h1234_5678);
        wr(slot(1, 2), 32'hFFFF_FFFF);
        rd(slot(0, 0), 32'hA5A5_0001, "R1 ch0 src");
        rd(slot(1, 1), 32'h1234_5678, "R1 ch1 dst");
        rd(slot(1, 2), 32'hFFFF_FFFF, "R1 ch1 ctrl");
        rd(slot(0, 1), 0, "R1 ch0 dst untouched");

        // R2 config width and unused slot words
        wr(slot(0, 3), 32'hFFFF_FFFF);
        rd(slot(0, 3), 32'h7, "R2 cfg unused bits");
        rd(slot(0, 4), 0, "R2 unused slot word");
        wr(slot(1, 3), 32'h1);

        // R6 enabled summary, R7 masks
        rd(12'h010, 32'h3, "R6 enabled");
        rd(12'h018, 32'h1, "R7 tc mask");
        rd(12'h01C, 32'h1, "R7 err mask");
        chk_irq(0, "R11 idle irq");

        // R8 completion on ch1 (masked)
        pulse(2'b10, 2'b00);
        rd(slot(1, 3), 0, "R8 ch1 enable cleared");
        rd(12'h000, 32'h2, "R8 tc status ch1");
        rd(12'h010, 32'h1, "R6 enabled after done");
        chk_irq(0, "R11 masked status no irq");

        // R8 completion on ch0 (unmasked)
        pulse(2'b01, 2'b00);
        rd(12'h000, 32'h3, "R8 tc status both");
        chk_irq(1, "R11 irq from tc");
        rd(slot(0, 3), 32'h6, "R8 ch0 enable cleared");

        // R10 clears
        wr(12'h004, 32'h0);
        rd(12'h000, 32'h3, "R10 write zero no effect");
        wr(12'h004, 32'h1);
        rd(12'h000, 32'h2, "R10 clear bit0");
        chk_irq(0, "R11 irq drops after clear");
        wr(12'h004, 32'h2, 2'b10, 2'b00);
        rd(12'h000, 32'h2, "R10 set wins over clear");

        // R8 done beats enable write
        wr(slot(1, 3), 32'h1, 2'b10, 2'b00);
        rd(slot(1, 3), 0, "R8 done beats enable write");

        // R9 error
        pulse(2'b00, 2'b01);
        rd(12'h008, 32'h1, "R9 err status");
        chk_irq(1, "R11 irq from err");
        wr(12'h00C, 32'h1);
        rd(12'h008, 0, "R10 err clear");
        chk_irq(0, "R11 irq after err clear");

        // R3 illegal slot
        wr(slot(2, 0), 32'hDEAD_BEEF);
        push(2, 1, "R3 bad after illegal write");
        @(negedge clk);
        rd(slot(0, 0), 32'hA5A5_0001, "R3 no alias into ch0");
        rd(slot(7, 3), 0, "R3 illegal read zero");
        push(2, 1, "R3 bad after illegal read");
        @(negedge clk);
        rd(slot(1, 1), 32'h1234_5678, "R3 legal read");
        push(2, 0, "R3 bad low after legal");
        @(negedge clk);

        // R4 identification
        for (int k = 0; k < 8; k++) begin
            logic [7:0] e;
            case (k)
                0: e = (NCH == 8) ? 8'h80 : 8'h81;
                1: e = 8'h10; 2: e = 8'h04; 3: e = 8'h0A;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05;
                default: e = 8'hB1;
            endcase
            rd(12'(32'hFE0 + 4 * k), {24'd0, e}, $sformatf("R4 id byte %0d", k));
        end

        // R5 global config
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, 32'h7, "R5 global cfg");
        wr(12'h014, 32'h2);
        rd(12'h014, 32'h2, "R5 global cfg rewrite");

        // R12 reset mid-run
        wr(slot(0, 3), 32'h7);
        pulse(2'b01, 2'b01);
        chk_irq(1, "R11 irq before reset");
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        chk_irq(0, "R12 irq after reset");
        rd(12'h000, 0, "R12 tc after reset");
        rd(12'h014, 0, "R12 gcfg after reset");
        rd(slot(0, 0), 0, "R12 src after reset");
        rd(slot(0, 3), 0, "R12 cfg after reset");

        repeat (2) @(posedge clk);
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule